// File: doc/BRIEF.md
# Display Controller Register Window

This block sits behind one memory-mapped aperture of a display controller. It lets a host reach four groups of registers through a single window. The first group is the byte-wide legacy port registers. The second is the 16-bit indexed mode-setting registers. The third is a small extension bank that holds the framebuffer byte-order flag. The fourth is a read-only monitor-identity table. Requests carry an address, a size code (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes), a write flag and write data. The block decodes the address and size, then replays the request as a sequence of narrow strobes on internal ports. The internal ports are a byte-wide legacy port, an index/data pair for the indexed registers, and a byte read port for the identity table. Read bytes are merged into one response word.

The host side is a valid/ready pair. The host raises `bus_valid` and must hold `bus_write`, `bus_addr`, `bus_size` and `bus_wdata` stable until it sees `bus_ready`. The transfer completes at the rising edge where both are high. The block stretches `bus_ready` low for as many cycles as the request needs internal strobes, so the back-pressure is exactly one cycle per strobe plus one. `bus_rdata` is valid while `bus_ready` is high.

The window layout is as follows:
- Identity table: 0x000–0x3FF.
- Legacy ports: 0x400–0x41F. Offset n maps to port 0x3C0+n.
- Indexed registers: 0x500–0x517.
- Extension bank: 0x600–0x607. The size register is at 0x600 and the byte-order register is at 0x604.

The parameters `EXT_EN` and `ID_EN` remove the extension bank and the identity table.

Top module: `dispwin_top`

## Requirements
- R1: An access at window offset 0x400+n drives the legacy port as port number 0x3C0+n. A 1-byte access issues exactly one legacy strobe (`lp_wr` carrying `bus_wdata[7:0]`, or `lp_rd`).
- R2: A 2- or 4-byte write to the legacy ports issues one byte write per byte, in ascending port order, with byte k of `bus_wdata` (bits 8k+7:8k) going to port 0x3C0+n+k. The low byte is therefore written first, so an index/data port pair is loaded by one word write.
- R3: A 2- or 4-byte legacy read returns port 0x3C0+n+k in bits 8k+7:8k of `bus_rdata`.
- R4: In the indexed window (0x500+m), the register index is m>>1. Every data strobe (`ix_wr` or `ix_rd`) is preceded, in the previous cycle, by an `ix_sel` strobe carrying the same `ix_index`.
- R5: In the indexed window, a 1- or 2-byte access is one 16-bit unit using `bus_wdata[15:0]` and returning in `bus_rdata[15:0]`. A 4-byte access is two units. The first unit is index m>>1 with bits 15:0. The second is index (m>>1)+1 with bits 31:16.
- R6: The extension bank responds only to 4-byte accesses (size code 2 or 3), and the size register at 0x600 reads 8. Other sizes in 0x600–0x607 behave as unmapped (R10).
- R7: The byte-order register at 0x604 reads 0xBEBEBEBE while `fb_big_endian` is 1 and 0x1E1E1E1E while it is 0. Writing 0xBEBEBEBE sets the flag, writing 0x1E1E1E1E clears it, and reset clears it.
- R8: A write to 0x604 of any other value leaves the flag unchanged. Writes to other extension offsets are ignored, and reads of extension offsets other than 0x600 and 0x604 return 0.
- R9: A read of the identity table at offset a issues one `id_rd` strobe per byte with `id_addr` = a+k, returning byte k in bits 8k+7:8k. Writes to the table issue no strobe.
- R10: An access outside all windows, or to a window disabled by its parameter, issues no strobe, drops the write and reads as all ones.
- R11: At most one internal strobe is issued per cycle, and strobes only occur while `bus_valid` is high. `bus_ready` first rises N+1 cycles after the request is first sampled, where N is the request's strobe count. It stays high until the handshake edge and is low in the cycle after it.
- R12: `bus_rdata` is masked to the access size: bits above the requested byte count are zero. `revision` reads 2 when the extension bank is present and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host request valid |
| bus_ready | output | 1 | Request complete; handshake when high with bus_valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (11) | Byte offset inside the window |
| bus_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| bus_wdata | input | 32 | Write data, little-endian byte lanes |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| lp_rd | output | 1 | Legacy port read strobe |
| lp_wr | output | 1 | Legacy port write strobe |
| lp_port | output | 10 | Legacy port number |
| lp_wdata | output | 8 | Legacy port write byte |
| lp_rdata | input | 8 | Legacy port read byte, sampled at the end of the lp_rd cycle |
| ix_sel | output | 1 | Indexed register index-load strobe |
| ix_rd | output | 1 | Indexed register data read strobe |
| ix_wr | output | 1 | Indexed register data write strobe |
| ix_index | output | 4 | Indexed register number |
| ix_wdata | output | 16 | Indexed register write data |
| ix_rdata | input | 16 | Indexed register read data, sampled at the end of the ix_rd cycle |
| id_rd | output | 1 | Identity table byte read strobe |
| id_addr | output | 10 | Identity table byte address |
| id_rdata | input | 8 | Identity table byte, sampled at the end of the id_rd cycle |
| fb_big_endian | output | 1 | Framebuffer byte-order flag |
| revision | output | 8 | Revision value reported for this configuration |

## Verification
The bench builds the block with its default parameters: both the extension bank and the identity table are present, with an 11-bit address. This puts every window reachable, including the byte-order flag transitions and the revision value of 2. The unmapped gaps between windows and the wrong-size extension accesses are what exercise the all-ones path. A behavioural model of the legacy port file, the index latch with its register array, and the identity table answers the strobes. Every strobe is matched, in order, against a queue of expected events built from the requirements.

// File: rtl/dispwin_pkg.sv
package dispwin_pkg;

  localparam int BUS_DW     = 32;
  localparam int LP_PORT_W  = 10;
  localparam int IX_IDX_W   = 4;
  localparam int ID_AW      = 10;
  localparam int OFF_W      = 10;
  localparam int STEP_W     = 3;

  localparam int unsigned ID_BASE  = 32'h000;
  localparam int unsigned ID_SPAN  = 32'h400;
  localparam int unsigned LP_BASE  = 32'h400;
  localparam int unsigned LP_SPAN  = 32'h020;
  localparam int unsigned IX_BASE  = 32'h500;
  localparam int unsigned IX_SPAN  = 32'h018;
  localparam int unsigned EXT_BASE = 32'h600;
  localparam int unsigned EXT_SPAN = 32'h008;

  localparam int unsigned LP_PORT_BASE  = 32'h3C0;
  localparam int unsigned EXT_SIZE_OFF  = 0;
  localparam int unsigned EXT_ORDER_OFF = 4;
  localparam logic [BUS_DW-1:0] ORDER_BIG    = 32'hBEBE_BEBE;
  localparam logic [BUS_DW-1:0] ORDER_LITTLE = 32'h1E1E_1E1E;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_ID,
    RG_LP,
    RG_IX,
    RG_EXT
  } region_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [BUS_DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic in_win(input int unsigned a, input int unsigned base,
                                  input int unsigned span);
    return (a >= base) && (a < base + span);
  endfunction

endpackage

// File: rtl/dispwin_decode.sv
module dispwin_decode
  import dispwin_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int EXT_EN = 1,
  parameter int ID_EN  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              write,
  output region_e           region,
  output logic [OFF_W-1:0]  offset,
  output logic [STEP_W-1:0] steps
);

  logic [2:0]  nbytes;
  int unsigned a_u;

  assign nbytes = size_bytes(size);
  assign a_u    = 32'(addr);

  always_comb begin
    region = RG_NONE;
    offset = '0;
    steps  = '0;
    if ((ID_EN != 0) && in_win(a_u, ID_BASE, ID_SPAN)) begin
      region = RG_ID;
      offset = OFF_W'(a_u - ID_BASE);
      steps  = write ? '0 : STEP_W'(nbytes);
    end else if (in_win(a_u, LP_BASE, LP_SPAN)) begin
      region = RG_LP;
      offset = OFF_W'(a_u - LP_BASE);
      steps  = STEP_W'(nbytes);
    end else if (in_win(a_u, IX_BASE, IX_SPAN)) begin
      region = RG_IX;
      offset = OFF_W'(a_u - IX_BASE);
      steps  = (nbytes == 3'd4) ? STEP_W'(4) : STEP_W'(2);
    end else if ((EXT_EN != 0) && in_win(a_u, EXT_BASE, EXT_SPAN) && (nbytes == 3'd4)) begin
      region = RG_EXT;
      offset = OFF_W'(a_u - EXT_BASE);
      steps  = STEP_W'(1);
    end
  end

endmodule

// File: rtl/dispwin_extbank.sv
module dispwin_extbank
  import dispwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        offset,
  input  logic              we,
  input  logic [BUS_DW-1:0] wdata,
  output logic [BUS_DW-1:0] rdata,
  output logic              big_endian
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      big_endian <= 1'b0;
    end else if (we && (offset == 3'(EXT_ORDER_OFF))) begin
      if (wdata == ORDER_BIG) begin
        big_endian <= 1'b1;
      end else if (wdata == ORDER_LITTLE) begin
        big_endian <= 1'b0;
      end
    end
  end

  always_comb begin
    if (offset == 3'(EXT_SIZE_OFF)) begin
      rdata = BUS_DW'(EXT_SPAN);
    end else if (offset == 3'(EXT_ORDER_OFF)) begin
      rdata = big_endian ? ORDER_BIG : ORDER_LITTLE;
    end else begin
      rdata = '0;
    end
  end

  // the flag may only move after an exact code written to the order register
  assert_flag_by_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(big_endian) |-> ($past(we) && ($past(offset) == 3'(EXT_ORDER_OFF)) &&
                              (($past(wdata) == ORDER_BIG) || ($past(wdata) == ORDER_LITTLE))));

endmodule

// File: rtl/dispwin_seq.sv
module dispwin_seq
  import dispwin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [BUS_DW-1:0]    bus_wdata,
  input  region_e              region,
  input  logic [OFF_W-1:0]     offset,
  input  logic [STEP_W-1:0]    steps,
  output logic                 bus_ready,
  output logic [BUS_DW-1:0]    acc,
  output logic                 lp_rd,
  output logic                 lp_wr,
  output logic [LP_PORT_W-1:0] lp_port,
  output logic [7:0]           lp_wdata,
  input  logic [7:0]           lp_rdata,
  output logic                 ix_sel,
  output logic                 ix_rd,
  output logic                 ix_wr,
  output logic [IX_IDX_W-1:0]  ix_index,
  output logic [15:0]          ix_wdata,
  input  logic [15:0]          ix_rdata,
  output logic                 id_rd,
  output logic [ID_AW-1:0]     id_addr,
  input  logic [7:0]           id_rdata,
  output logic                 ext_we,
  input  logic [BUS_DW-1:0]    ext_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_DONE} state_e;

  state_e            state;
  logic [STEP_W-1:0] step;
  logic              active;
  logic              phase;
  logic              unit;
  logic [1:0]        lane;

  assign active    = (state == ST_STEP);
  assign phase     = step[0];
  assign unit      = step[1];
  assign lane      = step[1:0];
  assign bus_ready = (state == ST_DONE);

  // strobes, one per cycle, driven from the current step
  assign lp_rd    = active && (region == RG_LP) && !bus_write;
  assign lp_wr    = active && (region == RG_LP) && bus_write;
  assign lp_port  = LP_PORT_W'(LP_PORT_BASE) + LP_PORT_W'(offset) + LP_PORT_W'(step);
  assign lp_wdata = bus_wdata[8*lane +: 8];

  assign ix_sel   = active && (region == RG_IX) && !phase;
  assign ix_rd    = active && (region == RG_IX) && phase && !bus_write;
  assign ix_wr    = active && (region == RG_IX) && phase && bus_write;
  assign ix_index = IX_IDX_W'(offset >> 1) + IX_IDX_W'(unit);
  assign ix_wdata = bus_wdata[16*unit +: 16];

  assign id_rd    = active && (region == RG_ID);
  assign id_addr  = ID_AW'(offset) + ID_AW'(step);

  assign ext_we   = active && (region == RG_EXT) && bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
      acc   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (bus_valid) begin
            step  <= '0;
            acc   <= (region == RG_NONE) ? '1 : '0;
            state <= (steps == '0) ? ST_DONE : ST_STEP;
          end
        end
        ST_STEP: begin
          case (region)
            RG_LP:   if (!bus_write) acc[8*lane +: 8] <= lp_rdata;
            RG_IX:   if (!bus_write && phase) acc[16*unit +: 16] <= ix_rdata;
            RG_ID:   acc[8*lane +: 8] <= id_rdata;
            RG_EXT:  if (!bus_write) acc <= ext_rdata;
            default: ;
          endcase
          step <= step + 1'b1;
          if (step == STEP_W'(steps - 1'b1)) begin
            state <= ST_DONE;
          end
        end
        default: begin
          if (bus_valid) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lp_rd, lp_wr, ix_sel, ix_rd, ix_wr, id_rd}));

  assert_strobe_in_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_rd || lp_wr || ix_sel || ix_rd || ix_wr || id_rd) |-> bus_valid);

  assert_ready_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_valid) |=> !bus_ready);

  assert_index_before_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ix_rd || ix_wr) |-> ($past(ix_sel) && (ix_index == $past(ix_index))));

  assert_port_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_wr && $past(lp_wr)) |-> (lp_port == LP_PORT_W'($past(lp_port) + 1'b1)));

endmodule

// File: rtl/dispwin_top.sv
module dispwin_top
  import dispwin_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int EXT_EN = 1,
  parameter int ID_EN  = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  output logic                 bus_ready,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [BUS_DW-1:0]    bus_wdata,
  output logic [BUS_DW-1:0]    bus_rdata,
  output logic                 lp_rd,
  output logic                 lp_wr,
  output logic [LP_PORT_W-1:0] lp_port,
  output logic [7:0]           lp_wdata,
  input  logic [7:0]           lp_rdata,
  output logic                 ix_sel,
  output logic                 ix_rd,
  output logic                 ix_wr,
  output logic [IX_IDX_W-1:0]  ix_index,
  output logic [15:0]          ix_wdata,
  input  logic [15:0]          ix_rdata,
  output logic                 id_rd,
  output logic [ID_AW-1:0]     id_addr,
  input  logic [7:0]           id_rdata,
  output logic                 fb_big_endian,
  output logic [7:0]           revision
);

  region_e           region;
  logic [OFF_W-1:0]  offset;
  logic [STEP_W-1:0] steps;
  logic [BUS_DW-1:0] acc;
  logic              ext_we;
  logic [BUS_DW-1:0] ext_rdata;

  dispwin_decode #(.ADDR_W(ADDR_W), .EXT_EN(EXT_EN), .ID_EN(ID_EN)) u_decode (
    .addr   (bus_addr),
    .size   (bus_size),
    .write  (bus_write),
    .region (region),
    .offset (offset),
    .steps  (steps)
  );

  dispwin_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_wdata (bus_wdata),
    .region    (region),
    .offset    (offset),
    .steps     (steps),
    .bus_ready (bus_ready),
    .acc       (acc),
    .lp_rd     (lp_rd),
    .lp_wr     (lp_wr),
    .lp_port   (lp_port),
    .lp_wdata  (lp_wdata),
    .lp_rdata  (lp_rdata),
    .ix_sel    (ix_sel),
    .ix_rd     (ix_rd),
    .ix_wr     (ix_wr),
    .ix_index  (ix_index),
    .ix_wdata  (ix_wdata),
    .ix_rdata  (ix_rdata),
    .id_rd     (id_rd),
    .id_addr   (id_addr),
    .id_rdata  (id_rdata),
    .ext_we    (ext_we),
    .ext_rdata (ext_rdata)
  );

  generate
    if (EXT_EN != 0) begin : g_ext
      dispwin_extbank u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .offset     (offset[2:0]),
        .we         (ext_we),
        .wdata      (bus_wdata),
        .rdata      (ext_rdata),
        .big_endian (fb_big_endian)
      );
    end else begin : g_noext
      assign ext_rdata     = '0;
      assign fb_big_endian = 1'b0;
    end
  endgenerate

  assign bus_rdata = acc & size_mask(bus_size);
  assign revision  = (EXT_EN != 0) ? 8'd2 : 8'd1;

endmodule

// File: tb/dispwin_top_tb.sv
module dispwin_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lp_rd, lp_wr;
  logic [9:0]  lp_port;
  logic [7:0]  lp_wdata, lp_rdata;
  logic        ix_sel, ix_rd, ix_wr;
  logic [3:0]  ix_index;
  logic [15:0] ix_wdata, ix_rdata;
  logic        id_rd;
  logic [9:0]  id_addr;
  logic [7:0]  id_rdata;
  logic        fb_big_endian;
  logic [7:0]  revision;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0]  lp_mem [64];
  logic [15:0] ix_mem [16];
  logic [3:0]  ix_cur = '0;
  bit          mdl_big = 1'b0;
  logic [31:0] expq [$];

  always #4ns clk = ~clk;

  function automatic logic [7:0] id_fn(input logic [9:0] a);
    return a[7:0] ^ 8'h5C ^ {6'd0, a[9:8]};
  endfunction

  assign lp_rdata = lp_mem[6'(lp_port - 10'h3C0)];
  assign ix_rdata = ix_mem[ix_cur];
  assign id_rdata = id_fn(id_addr);

  dispwin_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lp_rd(lp_rd), .lp_wr(lp_wr), .lp_port(lp_port), .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
    .ix_sel(ix_sel), .ix_rd(ix_rd), .ix_wr(ix_wr), .ix_index(ix_index),
    .ix_wdata(ix_wdata), .ix_rdata(ix_rdata),
    .id_rd(id_rd), .id_addr(id_addr), .id_rdata(id_rdata),
    .fb_big_endian(fb_big_endian), .revision(revision)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // event word: {kind[31:28], addr[27:16], data[15:0]}
  // kinds: 1 lp_wr, 2 lp_rd, 3 ix_sel, 4 ix_wr, 5 ix_rd, 6 id_rd
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] obs;
      int n;
      n = int'(lp_wr) + int'(lp_rd) + int'(ix_sel) + int'(ix_wr) + int'(ix_rd) + int'(id_rd);
      obs = '0;
      if (lp_wr)       obs = {4'd1, 2'b0, lp_port, 8'h0, lp_wdata};
      else if (lp_rd)  obs = {4'd2, 2'b0, lp_port, 16'h0};
      else if (ix_sel) obs = {4'd3, 8'h0, ix_index, 16'h0};
      else if (ix_wr)  obs = {4'd4, 8'h0, ix_index, ix_wdata};
      else if (ix_rd)  obs = {4'd5, 8'h0, ix_index, 16'h0};
      else if (id_rd)  obs = {4'd6, 2'b0, id_addr, 16'h0};
      if (n > 1) check(1'b0, "R11", "strobes in one cycle", 32'(n), 32'd1);
      if (n != 0) begin
        if (expq.size() == 0) begin
          check(1'b0, "R11", "unexpected strobe", obs, 32'h0);
        end else begin
          logic [31:0] e;
          e = expq.pop_front();
          check(obs == e, "R11", "strobe event", obs, e);
        end
        if (lp_wr)  lp_mem[6'(lp_port - 10'h3C0)] = lp_wdata;
        if (ix_sel) ix_cur = ix_index;
        if (ix_wr)  ix_mem[ix_cur] = ix_wdata;
      end
    end
  end

  task automatic do_acc(input bit wr, input int addr, input logic [1:0] sz,
                        input logic [31:0] wd, input string tag);
    int nb, n, cyc;
    logic [31:0] exp_rd, mask;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    mask = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    n = 0;
    exp_rd = '0;
    if (addr < 'h400) begin
      if (!wr) begin
        for (int k = 0; k < nb; k++) begin
          expq.push_back({4'd6, 12'(addr + k), 16'h0});
          exp_rd[8*k +: 8] = id_fn(10'(addr + k));
          n++;
        end
      end
    end else if (addr < 'h420) begin
      for (int k = 0; k < nb; k++) begin
        int p;
        p = 'h3C0 + addr - 'h400 + k;
        if (wr) expq.push_back({4'd1, 12'(p), 8'h0, wd[8*k +: 8]});
        else begin
          expq.push_back({4'd2, 12'(p), 16'h0});
          exp_rd[8*k +: 8] = lp_mem[6'(p - 'h3C0)];
        end
        n++;
      end
    end else if (addr >= 'h500 && addr < 'h518) begin
      for (int u = 0; u < ((nb == 4) ? 2 : 1); u++) begin
        int idx;
        idx = (addr - 'h500) / 2 + u;
        expq.push_back({4'd3, 12'(idx), 16'h0});
        if (wr) expq.push_back({4'd4, 12'(idx), wd[16*u +: 16]});
        else begin
          expq.push_back({4'd5, 12'(idx), 16'h0});
          exp_rd[16*u +: 16] = ix_mem[4'(idx)];
        end
        n += 2;
      end
    end else if (addr >= 'h600 && addr < 'h608 && nb == 4) begin
      n = 1;
      if (wr) begin
        if (addr == 'h604 && wd == 32'hBEBE_BEBE) mdl_big = 1'b1;
        if (addr == 'h604 && wd == 32'h1E1E_1E1E) mdl_big = 1'b0;
      end else begin
        exp_rd = (addr == 'h600) ? 32'd8 :
                 (addr == 'h604) ? (mdl_big ? 32'hBEBE_BEBE : 32'h1E1E_1E1E) : 32'h0;
      end
    end else begin
      exp_rd = 32'hFFFF_FFFF;
    end
    exp_rd &= mask;

    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = wr;
    bus_addr  = 11'(addr);
    bus_size  = sz;
    bus_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!bus_ready && cyc < 40);
    check(cyc == n + 1, "R11", {tag, " ready latency"}, 32'(cyc), 32'(n + 1));
    if (!wr) check(bus_rdata === exp_rd, tag, "read data", bus_rdata, exp_rd);
    @(negedge clk);
    bus_valid = 1'b0;
    check(!bus_ready, "R11", "ready dropped after handshake", 32'(bus_ready), 32'd0);
    check(expq.size() == 0, tag, "missing strobes", 32'(expq.size()), 32'd0);
    expq.delete();
  endtask

  initial begin
    #1600us;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) lp_mem[i] = 8'(8'h30 + 3 * i);
    for (int i = 0; i < 16; i++) ix_mem[i] = 16'(16'h0A00 + 16'h0111 * i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_ready, "R11", "reset ready", 32'(bus_ready), 32'd0);
    check(!fb_big_endian, "R7", "reset flag", 32'(fb_big_endian), 32'd0);
    check(revision == 8'd2, "R12", "revision", 32'(revision), 32'd2);

    // R1 single-byte legacy accesses
    do_acc(1'b0, 'h404, 2'd0, 32'h0, "R1");
    do_acc(1'b1, 'h400, 2'd0, 32'hFFFF_FF5A, "R1");
    do_acc(1'b0, 'h400, 2'd0, 32'h0, "R1");
    // R2 word write loads low byte first, R3 merged read
    do_acc(1'b1, 'h414, 2'd1, 32'h0000_BBAA, "R2");
    do_acc(1'b0, 'h414, 2'd1, 32'h0, "R3");
    do_acc(1'b1, 'h418, 2'd2, 32'h4433_2211, "R2");
    do_acc(1'b0, 'h417, 2'd2, 32'h0, "R3");
    // R4 and R5 indexed window
    do_acc(1'b1, 'h504, 2'd1, 32'h0000_1234, "R4");
    do_acc(1'b0, 'h504, 2'd1, 32'h0, "R4");
    do_acc(1'b1, 'h508, 2'd2, 32'hCAFE_BEEF, "R5");
    do_acc(1'b0, 'h508, 2'd2, 32'h0, "R5");
    do_acc(1'b0, 'h50A, 2'd0, 32'h0, "R5");
    do_acc(1'b0, 'h516, 2'd3, 32'h0, "R5");
    // R6 size register and size filtering
    do_acc(1'b0, 'h600, 2'd2, 32'h0, "R6");
    do_acc(1'b0, 'h600, 2'd1, 32'h0, "R6");
    // R7 byte order codes
    do_acc(1'b0, 'h604, 2'd2, 32'h0, "R7");
    do_acc(1'b1, 'h604, 2'd2, 32'hBEBE_BEBE, "R7");
    check(fb_big_endian == mdl_big, "R7", "flag after big code", 32'(fb_big_endian), 32'(mdl_big));
    do_acc(1'b0, 'h604, 2'd2, 32'h0, "R7");
    // R8 ignored values and offsets
    do_acc(1'b1, 'h604, 2'd2, 32'hBEBE_BEBF, "R8");
    check(fb_big_endian == 1'b1, "R8", "flag after bad code", 32'(fb_big_endian), 32'd1);
    do_acc(1'b1, 'h604, 2'd0, 32'h0000_001E, "R8");
    check(fb_big_endian == 1'b1, "R8", "flag after byte write", 32'(fb_big_endian), 32'd1);
    do_acc(1'b1, 'h600, 2'd2, 32'h1E1E_1E1E, "R8");
    check(fb_big_endian == 1'b1, "R8", "flag after size-reg write", 32'(fb_big_endian), 32'd1);
    do_acc(1'b0, 'h600, 2'd2, 32'h0, "R8");
    do_acc(1'b0, 'h601, 2'd2, 32'h0, "R8");
    do_acc(1'b1, 'h604, 2'd2, 32'h1E1E_1E1E, "R7");
    check(fb_big_endian == 1'b0, "R7", "flag after little code", 32'(fb_big_endian), 32'd0);
    // R9 identity table
    do_acc(1'b0, 'h123, 2'd2, 32'h0, "R9");
    do_acc(1'b0, 'h3FF, 2'd0, 32'h0, "R9");
    do_acc(1'b1, 'h010, 2'd2, 32'h1234_5678, "R9");
    // R10 unmapped, R12 size masking
    do_acc(1'b0, 'h700, 2'd1, 32'h0, "R10");
    do_acc(1'b0, 'h450, 2'd2, 32'h0, "R10");
    do_acc(1'b1, 'h520, 2'd2, 32'hDEAD_BEEF, "R10");
    do_acc(1'b0, 'h41F, 2'd0, 32'h0, "R12");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule